// File: doc/BRIEF.md
# Link and Priority Pause Quanta Timers

This block sits in the receive side of an Ethernet MAC and tracks how long the remote partner has asked the local transmitter to hold off. Its inputs are events that the frame parser has already decoded. A link-wide pause event carries one 16-bit quanta value. A priority flow control event carries an 8-bit class-enable mask and eight 16-bit quanta values.

The block keeps one countdown timer for the whole link and one for each of the eight priority classes. Each quanta is worth 512 counting cycles, and a timer advances only on cycles where the valid qualifier is high. A status output stays high for exactly the requested pause time.

A configuration input chooses how a link pause is used. It can gate the transmit client, or it can only be reported on the status bit.

Top module: `pause_quanta_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, all timers clear. After that edge `linkPauseActive`, `prioPauseActive` and `txHalt` are all zero.
- R2: A link pause event (`linkPauseEvt`=1) with quanta Q>0, sampled at an edge, sets `linkPauseActive` from that edge on. With `cycleValid` held high from the next cycle on, the bit falls after exactly Q*512 further edges.
- R3: A timer counts down only at edges where `cycleValid` is high. While `cycleValid` is low, every status bit holds its value and no timer expires.
- R4: A priority event (`pfcEvt`=1) loads timer i from `pfcQuanta[16*i+15:16*i]` for every i whose bit `pfcClassEn[i]` is 1. The timers of disabled classes keep running undisturbed.
- R5: Each bit i of `prioPauseActive` reflects only timer i. It stays high for exactly Q_i*512 valid cycles.
- R6: An event for a timer that is already running replaces the remaining count with the new quanta. The old and new counts are not added.
- R7: An event with zero quanta clears its timer, so the status bit is low after that edge.
- R8: When a load and a countdown fall on the same edge for one timer, the load wins. The full new count then remains.
- R9: With `stopTxEnable`=1, `txHalt` equals `linkPauseActive`. With `stopTxEnable`=0, `txHalt` stays low while `linkPauseActive` still reports the pause.
- R10: Priority timers never drive `txHalt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cycleValid | input | 1 | Counting qualifier; timers advance only when high |
| stopTxEnable | input | 1 | 1: link pause gates transmit; 0: report only |
| linkPauseEvt | input | 1 | Link-wide pause event strobe |
| linkPauseQuanta | input | 16 | Quanta carried by the link pause event |
| pfcEvt | input | 1 | Priority pause event strobe |
| pfcClassEn | input | 8 | Per-class enable of the priority event |
| pfcQuanta | input | 128 | Quanta of class i in bits [16*i+15:16*i] |
| linkPauseActive | output | 1 | Link pause timer running |
| prioPauseActive | output | 8 | Per-class pause timers running |
| txHalt | output | 1 | Transmit gating for the client |

## Verification
The assertions check every cycle that a timer loads the value presented with its event, and that it holds still on cycles without a valid tick. They also check that it steps down by one sub-count per tick, that the last tick of the last quanta drops the status bit, and that disabled classes and idle cycles raise no load strobe. The bench scenarios cover the end-to-end behaviour that only shows over hundreds of cycles. That includes the exact pause length for several quanta values, freezing and interleaving under a gappy valid pattern, overwrite of a running timer, a zero-quanta clear, multi-class priority loads, and the transmit gating under both settings of the configuration bit.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int PQ_NUM_PRIO = 8;
  localparam int PQ_QUANTA_W = 16;
  localparam int PQ_CYCLES_PER_QUANTA = 512;

  typedef struct packed {
    logic                   tick;
    logic                   loadLink;
    logic [PQ_NUM_PRIO-1:0] loadPrio;
  } pq_strobe_t;
endpackage

// File: rtl/pq_timer.sv
module pq_timer #(
  parameter int QUANTA_W = 16,
  parameter int CYCLES_PER_QUANTA = 512
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                load,
  input  logic [QUANTA_W-1:0] loadQuanta,
  output logic                active
);
  localparam int SUB_W = (CYCLES_PER_QUANTA > 1) ? $clog2(CYCLES_PER_QUANTA) : 1;
  localparam logic [SUB_W-1:0] SUB_MAX = SUB_W'(CYCLES_PER_QUANTA - 1);

  logic [QUANTA_W-1:0] quantaLeft;
  logic [SUB_W-1:0]    subLeft;
  logic                running;
  logic                subWrap;

  assign running = (quantaLeft != '0);
  assign subWrap = (subLeft == '0);
  assign active  = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      quantaLeft <= '0;
      subLeft    <= '0;
    end else if (load) begin
      quantaLeft <= loadQuanta;
      subLeft    <= SUB_MAX;
    end else if (tick && running) begin
      if (subWrap) begin
        quantaLeft <= quantaLeft - 1'b1;
        subLeft    <= SUB_MAX;
      end else begin
        subLeft <= subLeft - 1'b1;
      end
    end
  end

  // R6 and R8: a load always installs the full new count
  p_load_value_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (quantaLeft == $past(loadQuanta)) && (subLeft == SUB_MAX));

  // R7: zero quanta leaves the timer idle
  p_zero_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (load && loadQuanta == '0) |=> !active);

  // R3: no tick, no load, no change
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(quantaLeft) && $stable(subLeft));

  // R2: a tick inside a quanta steps the sub-count down by one
  p_sub_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && running && !subWrap) |=>
      (subLeft == $past(subLeft) - 1'b1) && $stable(quantaLeft));

  // R5: the final tick of the final quanta ends the pause
  p_expire_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && quantaLeft == QUANTA_W'(1) && subWrap) |=> !active);
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
  import pq_pkg::*;
#(
  parameter int NUM_PRIO = PQ_NUM_PRIO
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cycleValid,
  input  logic                stopTxEnable,
  input  logic                linkPauseEvt,
  input  logic                pfcEvt,
  input  logic [NUM_PRIO-1:0] pfcClassEn,
  input  logic                linkActive,
  output pq_strobe_t          strobes,
  output logic                txHalt
);
  always_comb begin
    strobes          = '0;
    strobes.tick     = cycleValid;
    strobes.loadLink = linkPauseEvt;
    for (int i = 0; i < NUM_PRIO; i++) begin
      strobes.loadPrio[i] = pfcEvt && pfcClassEn[i];
    end
  end

  // R9 and R10: only the link timer may gate, and only when enabled
  assign txHalt = stopTxEnable && linkActive;

  // R4: no priority event means no priority load
  p_no_stray_load_r4: assert property (@(posedge clk) disable iff (rst)
    !pfcEvt |-> (strobes.loadPrio == '0));

  // R4: never load a class whose enable bit is clear
  p_masked_load_r4: assert property (@(posedge clk) disable iff (rst)
    ((strobes.loadPrio & ~pfcClassEn) == '0));

  // R9: with gating off the client is never halted
  p_no_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !stopTxEnable |-> !txHalt);
endmodule

// File: rtl/pq_datapath.sv
module pq_datapath
  import pq_pkg::*;
#(
  parameter int NUM_PRIO = PQ_NUM_PRIO,
  parameter int QUANTA_W = PQ_QUANTA_W,
  parameter int CYCLES_PER_QUANTA = PQ_CYCLES_PER_QUANTA
) (
  input  logic                         clk,
  input  logic                         rst,
  input  pq_strobe_t                   strobes,
  input  logic [QUANTA_W-1:0]          linkQuanta,
  input  logic [NUM_PRIO*QUANTA_W-1:0] prioQuanta,
  output logic                         linkActive,
  output logic [NUM_PRIO-1:0]          prioActive
);
  pq_timer #(
    .QUANTA_W(QUANTA_W),
    .CYCLES_PER_QUANTA(CYCLES_PER_QUANTA)
  ) u_linkTimer (
    .clk(clk),
    .rst(rst),
    .tick(strobes.tick),
    .load(strobes.loadLink),
    .loadQuanta(linkQuanta),
    .active(linkActive)
  );

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_prio
    pq_timer #(
      .QUANTA_W(QUANTA_W),
      .CYCLES_PER_QUANTA(CYCLES_PER_QUANTA)
    ) u_prioTimer (
      .clk(clk),
      .rst(rst),
      .tick(strobes.tick),
      .load(strobes.loadPrio[g]),
      .loadQuanta(prioQuanta[g*QUANTA_W +: QUANTA_W]),
      .active(prioActive[g])
    );
  end
endmodule

// File: rtl/pause_quanta_tracker.sv
module pause_quanta_tracker
  import pq_pkg::*;
#(
  parameter int NUM_PRIO = PQ_NUM_PRIO,
  parameter int QUANTA_W = PQ_QUANTA_W,
  parameter int CYCLES_PER_QUANTA = PQ_CYCLES_PER_QUANTA
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cycleValid,
  input  logic                         stopTxEnable,
  input  logic                         linkPauseEvt,
  input  logic [QUANTA_W-1:0]          linkPauseQuanta,
  input  logic                         pfcEvt,
  input  logic [NUM_PRIO-1:0]          pfcClassEn,
  input  logic [NUM_PRIO*QUANTA_W-1:0] pfcQuanta,
  output logic                         linkPauseActive,
  output logic [NUM_PRIO-1:0]          prioPauseActive,
  output logic                         txHalt
);
  pq_strobe_t strobes;
  logic       linkActive;

  pq_ctrl #(.NUM_PRIO(NUM_PRIO)) u_ctrl (
    .clk(clk),
    .rst(rst),
    .cycleValid(cycleValid),
    .stopTxEnable(stopTxEnable),
    .linkPauseEvt(linkPauseEvt),
    .pfcEvt(pfcEvt),
    .pfcClassEn(pfcClassEn),
    .linkActive(linkActive),
    .strobes(strobes),
    .txHalt(txHalt)
  );

  pq_datapath #(
    .NUM_PRIO(NUM_PRIO),
    .QUANTA_W(QUANTA_W),
    .CYCLES_PER_QUANTA(CYCLES_PER_QUANTA)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .linkQuanta(linkPauseQuanta),
    .prioQuanta(pfcQuanta),
    .linkActive(linkActive),
    .prioActive(prioPauseActive)
  );

  assign linkPauseActive = linkActive;

  // R1: one cycle after reset every output is idle
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (!linkPauseActive && prioPauseActive == '0 && !txHalt));
endmodule

// File: tb/test_pause_quanta_tracker.sv
`timescale 1ns/1ps
module test_pause_quanta_tracker;
  localparam int NP = 8;
  localparam int QW = 16;
  localparam int CPQ = 512;

  logic clk = 1'b0;
  logic rst;
  logic cycleValid, stopTxEnable, linkPauseEvt, pfcEvt;
  logic [QW-1:0] linkPauseQuanta;
  logic [NP-1:0] pfcClassEn;
  logic [NP*QW-1:0] pfcQuanta;
  logic linkPauseActive, txHalt;
  logic [NP-1:0] prioPauseActive;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pause_quanta_tracker i_pause_quanta_tracker (
    .clk(clk), .rst(rst), .cycleValid(cycleValid), .stopTxEnable(stopTxEnable),
    .linkPauseEvt(linkPauseEvt), .linkPauseQuanta(linkPauseQuanta),
    .pfcEvt(pfcEvt), .pfcClassEn(pfcClassEn), .pfcQuanta(pfcQuanta),
    .linkPauseActive(linkPauseActive), .prioPauseActive(prioPauseActive),
    .txHalt(txHalt)
  );

  task automatic check(input string req, input longint act, input longint exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge; inputs change and outputs are sampled 1 ns after it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic linkEvent(input int q);
    linkPauseEvt = 1'b1; linkPauseQuanta = QW'(q);
    step();
    linkPauseEvt = 1'b0;
  endtask

  task automatic pfcEvent(input logic [NP-1:0] en, input logic [NP*QW-1:0] qv);
    pfcEvt = 1'b1; pfcClassEn = en; pfcQuanta = qv;
    step();
    pfcEvt = 1'b0; pfcClassEn = '0;
  endtask

  // edges until the link bit falls, with valid high on every cycle
  task automatic linkSteps(output int n);
    n = 0;
    cycleValid = 1'b1;
    while (linkPauseActive && n < 200000) begin step(); n++; end
  endtask

  task automatic doReset();
    rst = 1'b1; cycleValid = 1'b0; stopTxEnable = 1'b0;
    linkPauseEvt = 1'b0; linkPauseQuanta = '0;
    pfcEvt = 1'b0; pfcClassEn = '0; pfcQuanta = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    linkEvent(3);
    pfcEvent(8'hFF, {NP{16'd2}});
    stopTxEnable = 1'b1;
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 link", linkPauseActive, 0);
    check("R1 prio", prioPauseActive, 0);
    check("R1 halt", txHalt, 0);
    stopTxEnable = 1'b0;
  endtask

  task automatic t_linkLength();
    int n;
    cycleValid = 1'b1;
    linkEvent(1);
    check("R2 set", linkPauseActive, 1);
    linkSteps(n);
    check("R2 q=1 length", n, CPQ);
    linkEvent(3);
    linkSteps(n);
    check("R2 q=3 length", n, 3*CPQ);
  endtask

  task automatic t_validGate();
    int n;
    cycleValid = 1'b0;
    linkEvent(1);
    for (int i = 0; i < 2000; i++) step();
    check("R3 frozen", linkPauseActive, 1);
    n = 0;
    for (int i = 0; linkPauseActive && i < 10000; i++) begin
      cycleValid = (i % 2) == 1;
      step(); n++;
    end
    check("R3 alternate valid length", n, 2*CPQ);
  endtask

  task automatic t_pfcMulti();
    logic [NP*QW-1:0] qv;
    cycleValid = 1'b1;
    qv = '0;
    qv[3*QW +: QW] = 16'd3;
    pfcEvent(8'b0000_1000, qv);
    qv = '0;
    qv[0 +: QW] = 16'd1;
    qv[6*QW +: QW] = 16'd2;
    qv[3*QW +: QW] = 16'd9;  // class 3 disabled: must be ignored
    pfcEvent(8'b0100_0001, qv);
    check("R4 multi load", prioPauseActive, 8'b0100_1001);
    for (int i = 1; i < CPQ; i++) step();
    check("R5 q0 still high", prioPauseActive, 8'b0100_1001);
    step();
    check("R5 q0 expired", prioPauseActive, 8'b0100_1000);
    // class 3 started one cycle earlier with 3 quanta: ends at 3*CPQ-1 here
    for (int i = 0; i < CPQ - 1; i++) step();
    check("R4 class3 untouched", prioPauseActive[3], 1);
    step();
    check("R5 q6 expired", prioPauseActive, 8'b0000_1000);
    for (int i = 0; i < CPQ - 2; i++) step();
    check("R4 class3 kept own count", prioPauseActive[3], 1);
    step();
    check("R4 class3 expired", prioPauseActive, 0);
  endtask

  task automatic t_overwrite();
    int n;
    cycleValid = 1'b1;
    linkEvent(2);
    for (int i = 0; i < 300; i++) step();
    linkEvent(1);  // valid is high: load and decrement coincide
    linkSteps(n);
    check("R6 R8 overwrite length", n, CPQ);
    linkEvent(1);
    for (int i = 0; i < 100; i++) step();
    linkEvent(4);
    linkSteps(n);
    check("R6 no accumulate", n, 4*CPQ);
  endtask

  task automatic t_zero();
    cycleValid = 1'b1;
    linkEvent(5);
    for (int i = 0; i < 10; i++) step();
    linkEvent(0);
    check("R7 link zero clear", linkPauseActive, 0);
    pfcEvent(8'b0010_0000, {NP{16'd4}});
    pfcEvent(8'b0010_0000, '0);
    check("R7 prio zero clear", prioPauseActive, 0);
  endtask

  task automatic t_gating();
    int n;
    cycleValid = 1'b1;
    stopTxEnable = 1'b1;
    linkEvent(1);
    check("R9 halt on", txHalt, 1);
    linkSteps(n);
    check("R9 halt released", txHalt, 0);
    stopTxEnable = 1'b0;
    linkEvent(1);
    check("R9 report only status", linkPauseActive, 1);
    check("R9 report only halt", txHalt, 0);
    linkEvent(0);
    stopTxEnable = 1'b1;
    pfcEvent(8'hFF, {NP{16'd1}});
    check("R10 prio status", prioPauseActive, 8'hFF);
    check("R10 prio no halt", txHalt, 0);
    pfcEvent(8'hFF, '0);
    stopTxEnable = 1'b0;
  endtask

  initial begin
    doReset();
    check("R1 after reset", {txHalt, linkPauseActive, prioPauseActive}, 0);
    t_reset();
    t_linkLength();
    t_validGate();
    t_pfcMulti();
    t_overwrite();
    t_zero();
    t_gating();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #700000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule